// File: doc/BRIEF.md
# Packet Timestamp Capture Slots

This block keeps one hardware timestamp for transmitted packets and one for received packets. The surrounding MAC supplies a free-running 64-bit time value, an event strobe for each direction, and a qualifier. The qualifier says whether the packet matched the precision-time classification, which is decided upstream (an EtherType of 0x88F7 at layer 2, or UDP destination port 319). When a qualifying event arrives and the direction's slot is empty, the time on that same cycle is latched. A valid flag then rises.

A full slot is locked. Later qualifying events for that direction are dropped, and a sticky overrun flag records the loss. Software frees the slot by reading the low stamp word first and then the high stamp word. That read pair clears the valid flag and re-arms capture. A qualifying event on the same cycle as the re-arming high-word read is still stored.

The receive side has a mode field. One setting stamps every received event whatever its qualifier; the other requires a match. Both sides have an enable bit. Register access uses a simple strobe port, and read data is returned one cycle after the request.

Top module: `pkt_stamp_top`

## Requirements
- R1: After reset, every register reads 0: the enables, the receive mode, the valid flags, the overrun flags and all four stamp words.
- R2: When bit 0 of the transmit control register (address 0) is 1 and `tx_evt` and `tx_match` are both high in a cycle, the `time_now` value of that cycle is stored. The low half reads at address 2 and the high half at address 3. Transmit valid (address 0, bit 1) then reads 1.
- R3: While a direction's valid flag is 1, further qualifying events leave that direction's stored stamp unchanged.
- R4: A qualifying event that arrives while its slot is locked sets that direction's sticky overrun flag (transmit: address 0 bit 2; receive: address 1 bit 5). Writing 1 to that bit position of the control register clears the flag, and writing 0 there leaves it unchanged.
- R5: Reading the low stamp word while valid, then later reading the high word, clears valid and re-arms capture. A high-word read with no earlier low-word read leaves the slot locked.
- R6: A qualifying event on the same cycle as the re-arming high-word read is captured. Valid stays 1, the new time is stored, and no overrun is recorded.
- R7: The receive control register (address 1) holds an enable in bit 0 and a mode in bits 2:1. Mode 01 stamps every `rx_evt` regardless of `rx_match`. Every other mode value stamps only when `rx_match` is high. Receive valid is bit 4. The receive stamp reads at address 4 (low) and address 5 (high).
- R8: An event with its direction disabled, or an unmatched event in match mode, changes neither the valid flag nor the overrun flag.
- R9: A read request (`rd_en` with `rd_addr`) returns the addressed register on `rd_data` with `rd_valid` high on the next cycle. Writes to the stamp addresses 2 to 5 are ignored.
- R10: The two directions are independent. An event, read or write on one side never changes the other side's flags or stamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_now | input | 64 | Current time value |
| tx_evt | input | 1 | Transmit packet event strobe |
| tx_match | input | 1 | Transmit packet matched the timing classification |
| rx_evt | input | 1 | Receive packet event strobe |
| rx_match | input | 1 | Receive packet matched the timing classification |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 32 | Read data |

## Verification
Several rules are checked on every cycle by assertions: a qualifying event into an empty slot latches that cycle's time and raises valid, a locked slot holds its stamp steady, a drop raises overrun, and an unlocking read with no new event empties the slot. These hold under any stimulus. The bench scenarios are needed for the rest: the read-order rule (a high-word read alone does not unlock), the coincident unlock-and-capture case, overrun clearing, the receive stamp-all mode, and the independence of the two sides. These only become visible through register reads with known expected values.

// File: rtl/pkt_stamp_pkg.sv
package pkt_stamp_pkg;

  localparam int unsigned REG_AW = 3;

  localparam logic [REG_AW-1:0] A_TX_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] A_RX_CTRL = 3'd1;
  localparam logic [REG_AW-1:0] A_TX_LO   = 3'd2;
  localparam logic [REG_AW-1:0] A_TX_HI   = 3'd3;
  localparam logic [REG_AW-1:0] A_RX_LO   = 3'd4;
  localparam logic [REG_AW-1:0] A_RX_HI   = 3'd5;

  // control register bit positions
  localparam int unsigned TXB_EN    = 0;
  localparam int unsigned TXB_VALID = 1;
  localparam int unsigned TXB_OVR   = 2;
  localparam int unsigned RXB_EN    = 0;
  localparam int unsigned RXB_MODE  = 1;  // two bits
  localparam int unsigned RXB_VALID = 4;
  localparam int unsigned RXB_OVR   = 5;

  typedef enum logic [1:0] {
    RXM_MATCH  = 2'b00,
    RXM_ALL    = 2'b01,
    RXM_RSVD_A = 2'b10,
    RXM_RSVD_B = 2'b11
  } rx_mode_e;

  localparam int unsigned DIR_TX = 0;
  localparam int unsigned DIR_RX = 1;
  localparam int unsigned N_DIR  = 2;

endpackage

// File: rtl/stamp_slot.sv
// One capture slot: holds a single time value until software drains it
// by reading the low word followed by the high word.
module stamp_slot #(
  parameter int unsigned TW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] time_now,
  input  logic          qual,      // qualifying event this cycle
  input  logic          lo_rd,     // low-word read this cycle
  input  logic          hi_rd,     // high-word read this cycle
  input  logic          ovr_clr,   // software clears overrun
  output logic          valid,
  output logic          ovr,
  output logic          unlock,
  output logic [TW-1:0] stamp
);

  logic lo_seen;
  logic capture;
  logic drop;

  always_comb begin
    unlock  = hi_rd && lo_seen;
    capture = qual && (!valid || unlock);
    drop    = qual && valid && !unlock;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid   <= 1'b0;
      lo_seen <= 1'b0;
      stamp   <= '0;
    end else if (capture) begin
      valid   <= 1'b1;
      lo_seen <= 1'b0;
      stamp   <= time_now;
    end else if (unlock) begin
      valid   <= 1'b0;
      lo_seen <= 1'b0;
    end else if (lo_rd && valid) begin
      lo_seen <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ovr <= 1'b0;
    else if (drop)    ovr <= 1'b1;
    else if (ovr_clr) ovr <= 1'b0;
  end

endmodule

// File: rtl/stamp_regs.sv
// Control registers, access decode and registered read mux.
module stamp_regs
  import pkt_stamp_pkg::*;
#(
  parameter int unsigned TW = 64,
  parameter int unsigned DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] rd_addr,
  input  logic [TW-1:0]     tx_stamp,
  input  logic [TW-1:0]     rx_stamp,
  input  logic              tx_valid,
  input  logic              rx_valid,
  input  logic              tx_ovr,
  input  logic              rx_ovr,
  output logic              tx_en,
  output logic              rx_en,
  output rx_mode_e          rx_mode,
  output logic              tx_ovr_clr,
  output logic              rx_ovr_clr,
  output logic              tx_lo_rd,
  output logic              tx_hi_rd,
  output logic              rx_lo_rd,
  output logic              rx_hi_rd,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data
);

  localparam int unsigned HW = TW - DW;

  logic          wr_tx, wr_rx;
  logic [DW-1:0] rd_mux;

  always_comb begin
    wr_tx      = wr_en && (wr_addr == A_TX_CTRL);
    wr_rx      = wr_en && (wr_addr == A_RX_CTRL);
    tx_ovr_clr = wr_tx && wr_data[TXB_OVR];
    rx_ovr_clr = wr_rx && wr_data[RXB_OVR];
    tx_lo_rd   = rd_en && (rd_addr == A_TX_LO);
    tx_hi_rd   = rd_en && (rd_addr == A_TX_HI);
    rx_lo_rd   = rd_en && (rd_addr == A_RX_LO);
    rx_hi_rd   = rd_en && (rd_addr == A_RX_HI);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en   <= 1'b0;
      rx_en   <= 1'b0;
      rx_mode <= RXM_MATCH;
    end else begin
      if (wr_tx) tx_en <= wr_data[TXB_EN];
      if (wr_rx) begin
        rx_en   <= wr_data[RXB_EN];
        rx_mode <= rx_mode_e'(wr_data[RXB_MODE +: 2]);
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (rd_addr)
      A_TX_CTRL: begin
        rd_mux[TXB_EN]    = tx_en;
        rd_mux[TXB_VALID] = tx_valid;
        rd_mux[TXB_OVR]   = tx_ovr;
      end
      A_RX_CTRL: begin
        rd_mux[RXB_EN]         = rx_en;
        rd_mux[RXB_MODE +: 2]  = rx_mode;
        rd_mux[RXB_VALID]      = rx_valid;
        rd_mux[RXB_OVR]        = rx_ovr;
      end
      A_TX_LO: rd_mux        = tx_stamp[DW-1:0];
      A_TX_HI: rd_mux[HW-1:0] = tx_stamp[TW-1:DW];
      A_RX_LO: rd_mux        = rx_stamp[DW-1:0];
      A_RX_HI: rd_mux[HW-1:0] = rx_stamp[TW-1:DW];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

endmodule

// File: rtl/pkt_stamp_top.sv
module pkt_stamp_top
  import pkt_stamp_pkg::*;
#(
  parameter int unsigned TW = 64,
  parameter int unsigned DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TW-1:0]     time_now,
  input  logic              tx_evt,
  input  logic              tx_match,
  input  logic              rx_evt,
  input  logic              rx_match,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] rd_addr,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data
);

  logic     tx_en, rx_en;
  rx_mode_e rx_mode;
  logic     tx_ovr_clr, rx_ovr_clr;
  logic     tx_lo_rd, tx_hi_rd, rx_lo_rd, rx_hi_rd;

  logic [N_DIR-1:0] qual, lo_rd, hi_rd, ovr_clr, valid, ovr, unlock;
  logic [TW-1:0]    stamp [N_DIR];

  always_comb begin
    qual[DIR_TX]    = tx_en && tx_evt && tx_match;
    qual[DIR_RX]    = rx_en && rx_evt && (rx_match || (rx_mode == RXM_ALL));
    lo_rd[DIR_TX]   = tx_lo_rd;
    lo_rd[DIR_RX]   = rx_lo_rd;
    hi_rd[DIR_TX]   = tx_hi_rd;
    hi_rd[DIR_RX]   = rx_hi_rd;
    ovr_clr[DIR_TX] = tx_ovr_clr;
    ovr_clr[DIR_RX] = rx_ovr_clr;
  end

  for (genvar d = 0; d < N_DIR; d++) begin : g_slot
    stamp_slot #(.TW(TW)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .time_now (time_now),
      .qual     (qual[d]),
      .lo_rd    (lo_rd[d]),
      .hi_rd    (hi_rd[d]),
      .ovr_clr  (ovr_clr[d]),
      .valid    (valid[d]),
      .ovr      (ovr[d]),
      .unlock   (unlock[d]),
      .stamp    (stamp[d])
    );
  end

  stamp_regs #(.TW(TW), .DW(DW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .tx_stamp   (stamp[DIR_TX]),
    .rx_stamp   (stamp[DIR_RX]),
    .tx_valid   (valid[DIR_TX]),
    .rx_valid   (valid[DIR_RX]),
    .tx_ovr     (ovr[DIR_TX]),
    .rx_ovr     (ovr[DIR_RX]),
    .tx_en      (tx_en),
    .rx_en      (rx_en),
    .rx_mode    (rx_mode),
    .tx_ovr_clr (tx_ovr_clr),
    .rx_ovr_clr (rx_ovr_clr),
    .tx_lo_rd   (tx_lo_rd),
    .tx_hi_rd   (tx_hi_rd),
    .rx_lo_rd   (rx_lo_rd),
    .rx_hi_rd   (rx_hi_rd),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );

endmodule

// File: rtl/pkt_stamp_chk.sv
module pkt_stamp_chk
  import pkt_stamp_pkg::*;
#(
  parameter int unsigned TW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic [TW-1:0] time_now,
  input logic          tx_evt,
  input logic          tx_match,
  input logic          rx_evt,
  input logic          rx_match,
  input logic          tx_en,
  input logic          rx_en,
  input rx_mode_e      rx_mode,
  input logic [1:0]    valid,
  input logic [1:0]    ovr,
  input logic [1:0]    unlock,
  input logic [TW-1:0] tx_stamp,
  input logic [TW-1:0] rx_stamp,
  input logic          rd_en,
  input logic          rd_valid
);

  logic tx_q, rx_q;
  always_comb begin
    tx_q = tx_evt && tx_match && tx_en;
    rx_q = rx_evt && rx_en && (rx_match || rx_mode == RXM_ALL);
  end

  // R2: empty transmit slot latches the time of the event cycle
  a_r2_tx_capture: assert property (@(posedge clk) disable iff (rst)
    tx_q && !valid[0] |=> valid[0] && tx_stamp == $past(time_now));

  // R7: receive capture obeys enable and mode
  a_r7_rx_capture: assert property (@(posedge clk) disable iff (rst)
    rx_q && !valid[1] |=> valid[1] && rx_stamp == $past(time_now));

  // R3: a locked slot keeps its value unless it is unlocked
  a_r3_tx_hold: assert property (@(posedge clk) disable iff (rst)
    valid[0] && !unlock[0] |=> $stable(tx_stamp) && valid[0]);
  a_r3_rx_hold: assert property (@(posedge clk) disable iff (rst)
    valid[1] && !unlock[1] |=> $stable(rx_stamp) && valid[1]);

  // R4: an event into a locked slot sets overrun
  a_r4_tx_overrun: assert property (@(posedge clk) disable iff (rst)
    tx_q && valid[0] && !unlock[0] |=> ovr[0]);
  a_r4_rx_overrun: assert property (@(posedge clk) disable iff (rst)
    rx_q && valid[1] && !unlock[1] |=> ovr[1]);

  // R5: unlocking with no new event empties the slot
  a_r5_tx_rearm: assert property (@(posedge clk) disable iff (rst)
    unlock[0] && !tx_q |=> !valid[0]);
  a_r5_rx_rearm: assert property (@(posedge clk) disable iff (rst)
    unlock[1] && !rx_q |=> !valid[1]);

  // R8: no event, no new valid flag
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !tx_q && !valid[0] |=> !valid[0]);

  // R9: read data follows the request by one cycle
  a_r9_rd_latency: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

endmodule

bind pkt_stamp_top pkt_stamp_chk #(.TW(TW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .time_now (time_now),
  .tx_evt   (tx_evt),
  .tx_match (tx_match),
  .rx_evt   (rx_evt),
  .rx_match (rx_match),
  .tx_en    (tx_en),
  .rx_en    (rx_en),
  .rx_mode  (rx_mode),
  .valid    (valid),
  .ovr      (ovr),
  .unlock   (unlock),
  .tx_stamp (stamp[0]),
  .rx_stamp (stamp[1]),
  .rd_en    (rd_en),
  .rd_valid (rd_valid)
);

// File: tb/test_pkt_stamp_top.sv
module test_pkt_stamp_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] tnow;
  logic        tx_evt = 0, tx_match = 0, rx_evt = 0, rx_match = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [2:0]  wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0;
  logic        rd_valid;
  logic [31:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk)
    if (rst) tnow <= 64'h0000_0012_3456_0000;
    else     tnow <= tnow + 64'h0000_0001_0000_0007;

  pkt_stamp_top i_pkt_stamp_top (
    .clk(clk), .rst(rst), .time_now(tnow),
    .tx_evt(tx_evt), .tx_match(tx_match),
    .rx_evt(rx_evt), .rx_match(rx_match),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // monitor: pops expected read results as they come out
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R9: unexpected read data got %h expected none", rd_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          fails++;
          $display("FAIL %s: got %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
    rd_en = 1; rd_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic tx_pulse(input logic m, output logic [63:0] t);
    tx_evt = 1; tx_match = m; t = tnow;
    @(negedge clk);
    tx_evt = 0; tx_match = 0;
  endtask

  task automatic rx_pulse(input logic m, output logic [63:0] t);
    rx_evt = 1; rx_match = m; t = tnow;
    @(negedge clk);
    rx_evt = 0; rx_match = 0;
  endtask

  // high-word read coinciding with a transmit event
  task automatic rd_with_tx(input logic [2:0] a, input logic [31:0] e,
                            input string tg, output logic [63:0] t);
    rd_en = 1; rd_addr = a; tx_evt = 1; tx_match = 1; t = tnow;
    exp_q.push_back(e); tag_q.push_back(tg);
    @(negedge clk);
    rd_en = 0; tx_evt = 0; tx_match = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] t1, t2, t3, t4, t5, tx_;
    repeat (3) @(posedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) rd(3'(a), 32'h0, "R1 reset");

    // R2 / R8 transmit enable and qualifier
    wr(3'd0, 32'h1);
    rd(3'd0, 32'h1, "R2 tx enable readback");
    tx_pulse(1'b0, tx_);
    rd(3'd0, 32'h1, "R8 unmatched tx ignored");
    tx_pulse(1'b1, t1);
    rd(3'd0, 32'h3, "R2 tx valid");
    // R3 / R4 locked slot
    tx_pulse(1'b1, tx_);
    rd(3'd0, 32'h7, "R4 tx overrun set");
    rd(3'd2, t1[31:0],  "R3 tx lo held");
    rd(3'd3, t1[63:32], "R3 tx hi held");
    rd(3'd0, 32'h5, "R5 tx rearmed after lo+hi");
    wr(3'd0, 32'h1);
    rd(3'd0, 32'h5, "R4 write 0 keeps overrun");
    wr(3'd0, 32'h5);
    rd(3'd0, 32'h1, "R4 overrun cleared");

    // R5 high read without low read keeps lock
    tx_pulse(1'b1, t2);
    rd(3'd3, t2[63:32], "R5 tx hi only");
    rd(3'd0, 32'h3, "R5 hi-only keeps valid");
    // R6 coincident unlock and capture
    rd(3'd2, t2[31:0], "R6 tx lo");
    rd_with_tx(3'd3, t2[63:32], "R6 tx hi", t3);
    rd(3'd0, 32'h3, "R6 valid kept, no overrun");
    rd(3'd2, t3[31:0],  "R6 new lo");
    rd(3'd3, t3[63:32], "R6 new hi");
    rd(3'd0, 32'h1, "R5 drained");
    // R9 stamp writes ignored
    wr(3'd2, 32'hDEAD_BEEF);
    wr(3'd3, 32'hCAFE_F00D);
    rd(3'd2, t3[31:0],  "R9 lo write ignored");
    rd(3'd3, t3[63:32], "R9 hi write ignored");

    // R7 receive match mode
    wr(3'd1, 32'h1);
    rx_pulse(1'b0, tx_);
    rd(3'd1, 32'h1, "R7 rx match mode ignores unmatched");
    rx_pulse(1'b1, t4);
    rd(3'd1, 32'h11, "R7 rx valid");
    rd(3'd0, 32'h1, "R10 tx untouched by rx");
    rd(3'd4, t4[31:0],  "R7 rx lo");
    rd(3'd5, t4[63:32], "R7 rx hi");
    rd(3'd1, 32'h1, "R5 rx drained");

    // R7 stamp-all mode
    wr(3'd1, 32'h3);
    rx_pulse(1'b0, t5);
    rd(3'd1, 32'h13, "R7 stamp-all captures unmatched");
    rx_pulse(1'b0, tx_);
    rd(3'd1, 32'h33, "R4 rx overrun");
    rd(3'd0, 32'h1, "R10 tx flags untouched");
    rd(3'd4, t5[31:0],  "R7 rx all lo");
    rd(3'd5, t5[63:32], "R7 rx all hi");
    rd(3'd1, 32'h23, "R5 rx rearmed");
    wr(3'd1, 32'h23);
    rd(3'd1, 32'h3, "R4 rx overrun cleared");
    rd(3'd2, t3[31:0], "R10 tx stamp untouched");

    // R8 disabled transmit
    wr(3'd0, 32'h0);
    tx_pulse(1'b1, tx_);
    rd(3'd0, 32'h0, "R8 disabled tx ignored");
    rd(3'd3, t3[63:32], "R8 disabled tx stamp kept");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R9: got %0d pending reads expected 0", exp_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule